// File: doc/BRIEF.md
# Dual-ADC pixel merger with per-line CRC10 word

This block takes the samples of two analog-to-digital converters that deliver one pixel each on the same strobe and turns them into a single 10-bit pixel stream: the sample from converter A goes out first, the sample from converter B on the following cycle. A serial link transmitter consumes the merged stream.

For every line, framed by a start flag and an end flag on the input, the block keeps a 10-bit cyclic redundancy checksum. The first pixel of a line is loaded straight into the checksum register. Each later pixel is folded in with a full-width parallel update using the generator x^10 + x^9 + x^6 + x^3 + x^2 + x + 1. When the checksum enable was high at line start, the finished checksum is sent as one extra word, marked by a flag, directly after the last pixel of the line.

The control is a three-state machine:
- `ST_IDLE` accepts a pair.
- `ST_EMIT_B` sends the held B sample.
- `ST_EMIT_CRC` sends the checksum.

Its transitions are:
- `ST_IDLE -> ST_EMIT_B` when a pair with a valid B sample is accepted.
- `ST_IDLE -> ST_EMIT_CRC` when a lone A sample closes a protected line.
- `ST_EMIT_B -> ST_EMIT_CRC` when the held B sample closes a protected line.
- `ST_EMIT_B -> ST_IDLE` and `ST_EMIT_CRC -> ST_IDLE` otherwise.
- `ST_IDLE -> ST_IDLE` when nothing is accepted, or when a lone A sample does not close a protected line.

Top module: `crc_pixel_merge`

## Requirements
- R1: A pair is accepted on a rising edge where `a_valid` and `in_ready` are both high. The A sample appears on `out_data` with `out_valid` high on the next cycle. When `b_valid` was high, the B sample follows on the cycle after that.
- R2: When `b_valid` is low on an accepted pair, only the A sample is emitted. `b_valid` or `b_data` presented without `a_valid` produce no output word.
- R3: The checksum update processes the 10 pixel bits MSB first in one cycle. For each bit, the incoming bit is XORed with the register MSB and the register shifts left by one. When that XOR is 1, the register is XORed with the mask 0x24F.
- R4: On a pair carrying `line_start`, the checksum register is set to the A sample with no update. The B sample and all later pixels of the line are folded in through the R3 step.
- R5: When a line ends and the enable captured for that line is high, the checksum word is emitted on the cycle right after the line's last pixel, with `out_is_crc` high. All pixel words have `out_is_crc` low.
- R6: `crc_en` is sampled only on the pair carrying `line_start` and holds for the whole line. A line whose captured enable is low passes through with no extra word, whatever `crc_en` does afterwards.
- R7: `in_ready` is low on every cycle in which a B sample or a checksum word of an already accepted pair is still to be emitted. Otherwise it is high.
- R8: A line of exactly one pixel (A only, with `line_start` and `line_end` together) emits that pixel, then a checksum word equal to the pixel value.
- R9: A synchronous active-high reset clears `out_valid` and `out_is_crc`, clears the checksum register, and leaves `in_ready` high.
- R10: With input pairs offered on every cycle that `in_ready` is high, `out_valid` stays high with no gap cycle between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_data | input | 10 | Sample from converter A |
| b_data | input | 10 | Sample from converter B |
| a_valid | input | 1 | Pair strobe; A sample valid |
| b_valid | input | 1 | B sample of the pair valid |
| line_start | input | 1 | Pair opens a line |
| line_end | input | 1 | Pair closes a line |
| crc_en | input | 1 | Append checksum for the line being opened |
| in_ready | output | 1 | Block can accept a pair this cycle |
| out_data | output | 10 | Merged pixel or checksum word |
| out_valid | output | 1 | `out_data` holds a word |
| out_is_crc | output | 1 | Current word is the line checksum |

## Verification
A corrupted checksum register stays invisible until a protected line closes. At that point the extra word differs from the expected value, one cycle after the last pixel. A wrong state register shows up within one or two cycles: as a B sample missing from the output, a duplicated word, a gap in `out_valid`, or `in_ready` high while a word is still owed. A wrong captured enable shows up at line end as a missing or unexpected word flagged by `out_is_crc`.

// File: rtl/crcpix_pkg.sv
package crcpix_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_EMIT_B   = 2'd1,
        ST_EMIT_CRC = 2'd2
    } emit_state_t;
endpackage

// File: rtl/crc10_step.sv
// One full-width checksum update: all pixel bits folded in one cycle,
// MSB first, as an unrolled chain of single-bit divisions.
module crc10_step #(
    parameter int          W    = 10,
    parameter logic [W-1:0] POLY = 10'h24F
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] pix,
    output logic [W-1:0] crc_out
);
    logic [W-1:0] chain [0:W];

    assign chain[0] = crc_in;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic fb;
        assign fb = pix[W-1-i] ^ chain[i][W-1];
        assign chain[i+1] = {chain[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign crc_out = chain[W];
endmodule

// File: rtl/pair_crc.sv
// Next checksum after one accepted pair: seeds on line start, then
// folds the B sample when it is present.
module pair_crc #(
    parameter int          W    = 10,
    parameter logic [W-1:0] POLY = 10'h24F
) (
    input  logic [W-1:0] crc_q,
    input  logic [W-1:0] a_pix,
    input  logic [W-1:0] b_pix,
    input  logic         seed,
    input  logic         use_b,
    output logic [W-1:0] crc_next
);
    logic [W-1:0] a_step;
    logic [W-1:0] after_a;
    logic [W-1:0] b_step;

    crc10_step #(.W(W), .POLY(POLY)) i_step_a (
        .crc_in (crc_q),
        .pix    (a_pix),
        .crc_out(a_step)
    );

    assign after_a = seed ? a_pix : a_step;

    crc10_step #(.W(W), .POLY(POLY)) i_step_b (
        .crc_in (after_a),
        .pix    (b_pix),
        .crc_out(b_step)
    );

    assign crc_next = use_b ? b_step : after_a;
endmodule

// File: rtl/crc_pixel_merge.sv
module crc_pixel_merge #(
    parameter int             PIX_W = 10,
    parameter logic [PIX_W-1:0] POLY  = 10'h24F
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] a_data,
    input  logic [PIX_W-1:0] b_data,
    input  logic             a_valid,
    input  logic             b_valid,
    input  logic             line_start,
    input  logic             line_end,
    input  logic             crc_en,
    output logic             in_ready,
    output logic [PIX_W-1:0] out_data,
    output logic             out_valid,
    output logic             out_is_crc
);
    import crcpix_pkg::*;

    emit_state_t      state_q, state_d;
    logic [PIX_W-1:0] b_hold_q;
    logic [PIX_W-1:0] crc_q;
    logic [PIX_W-1:0] crc_next;
    logic             line_crc_q;
    logic             crc_pend_q;
    logic             accept;
    logic             crc_on;
    logic             append;

    assign in_ready = (state_q == ST_IDLE);
    assign accept   = a_valid && in_ready;
    assign crc_on   = line_start ? crc_en : line_crc_q;
    assign append   = line_end && crc_on;

    pair_crc #(.W(PIX_W), .POLY(POLY)) i_pair_crc (
        .crc_q   (crc_q),
        .a_pix   (a_data),
        .b_pix   (b_data),
        .seed    (line_start),
        .use_b   (b_valid),
        .crc_next(crc_next)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (b_valid)     state_d = ST_EMIT_B;
                    else if (append) state_d = ST_EMIT_CRC;
                    else             state_d = ST_IDLE;
                end
            end
            ST_EMIT_B:   state_d = crc_pend_q ? ST_EMIT_CRC : ST_IDLE;
            ST_EMIT_CRC: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // line datapath: checksum, held B sample, captured enable
    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q      <= '0;
            b_hold_q   <= '0;
            line_crc_q <= 1'b0;
            crc_pend_q <= 1'b0;
        end else if (accept) begin
            crc_q      <= crc_next;
            b_hold_q   <= b_data;
            crc_pend_q <= append;
            if (line_start) line_crc_q <= crc_en;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_is_crc <= 1'b0;
            out_data   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    out_valid  <= accept;
                    out_is_crc <= 1'b0;
                    out_data   <= accept ? a_data : '0;
                end
                ST_EMIT_B: begin
                    out_valid  <= 1'b1;
                    out_is_crc <= 1'b0;
                    out_data   <= b_hold_q;
                end
                ST_EMIT_CRC: begin
                    out_valid  <= 1'b1;
                    out_is_crc <= 1'b1;
                    out_data   <= crc_q;
                end
                default: begin
                    out_valid  <= 1'b0;
                    out_is_crc <= 1'b0;
                    out_data   <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/crc_pixel_merge_chk.sv
module crc_pixel_merge_chk #(
    parameter int PIX_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic [PIX_W-1:0] a_data,
    input logic [PIX_W-1:0] b_data,
    input logic             a_valid,
    input logic             b_valid,
    input logic             line_start,
    input logic             line_end,
    input logic             crc_en,
    input logic             in_ready,
    input logic [PIX_W-1:0] out_data,
    input logic             out_valid,
    input logic             out_is_crc
);
    assert_a_next_R1: assert property (@(posedge clk) disable iff (rst)
        (a_valid && in_ready) |=>
            (out_valid && !out_is_crc && out_data == $past(a_data)));

    assert_b_follow_R1: assert property (@(posedge clk) disable iff (rst)
        (a_valid && in_ready && b_valid) |=> ##1
            (out_valid && !out_is_crc && out_data == $past(b_data, 2)));

    assert_flag_valid_R5: assert property (@(posedge clk) disable iff (rst)
        out_is_crc |-> out_valid);

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (a_valid && in_ready && b_valid) |=> !in_ready);

    assert_single_R8: assert property (@(posedge clk) disable iff (rst)
        (a_valid && in_ready && !b_valid && line_start && line_end && crc_en) |=> ##1
            (out_is_crc && out_data == $past(a_data, 2)));

    assert_reset_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_is_crc && in_ready));
endmodule

bind crc_pixel_merge crc_pixel_merge_chk #(.PIX_W(PIX_W)) i_chk (.*);

// File: tb/test_crc_pixel_merge.sv
module test_crc_pixel_merge;
    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] a_data, b_data;
    logic       a_valid, b_valid, line_start, line_end, crc_en;
    logic       in_ready, out_valid, out_is_crc;
    logic [9:0] out_data;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    crc_pixel_merge i_crc_pixel_merge (
        .clk(clk), .rst(rst), .a_data(a_data), .b_data(b_data),
        .a_valid(a_valid), .b_valid(b_valid), .line_start(line_start),
        .line_end(line_end), .crc_en(crc_en), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_is_crc(out_is_crc)
    );

    // stimulus entry: {av, bv, ls, le, ce, a[9:0], b[9:0]}
    logic [24:0] stim[$];
    logic [10:0] exp_q[$];   // {is_crc, word}
    string       tag_q[$];
    string       crc_tag = "R5 R3 R4";
    int          model_crc = 0;
    bit          model_en  = 0;

    function automatic int div_step(int c, int d);
        int r = c;
        for (int k = 9; k >= 0; k--) begin
            int top = ((r >> 9) & 1) ^ ((d >> k) & 1);
            r = (r << 1) & 10'h3FF;
            if (top == 1) r = r ^ 10'h24F;
        end
        return r;
    endfunction

    task automatic add(bit av, bit bv, bit ls, bit le, bit ce, int a, int b);
        stim.push_back({av, bv, ls, le, ce, a[9:0], b[9:0]});
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic compare_cycle();
        check(out_valid == (exp_q.size() != 0), "R10 R2 out_valid", out_valid, exp_q.size() != 0);
        if (out_valid && exp_q.size() != 0) begin
            logic [10:0] e = exp_q.pop_front();
            string       t = tag_q.pop_front();
            check(out_data == e[9:0], t, out_data, e[9:0]);
            check(out_is_crc == e[10], {t, " flag"}, out_is_crc, e[10]);
        end
        check(in_ready == (exp_q.size() == 0), "R7 in_ready", in_ready, exp_q.size() == 0);
    endtask

    task automatic drive_cycle();
        a_valid = 0; b_valid = 0; line_start = 0; line_end = 0; crc_en = 0;
        if (stim.size() == 0) return;
        if (stim[0][24] == 1'b0) begin
            logic [24:0] s = stim.pop_front();
            b_valid = s[23]; b_data = s[9:0]; a_data = s[19:10];
            line_start = s[22]; line_end = s[21]; crc_en = s[20];
        end else if (in_ready) begin
            logic [24:0] s = stim.pop_front();
            int a = int'(s[19:10]);
            int b = int'(s[9:0]);
            a_valid = 1; b_valid = s[23]; line_start = s[22];
            line_end = s[21]; crc_en = s[20]; a_data = s[19:10]; b_data = s[9:0];
            if (s[22]) begin
                model_crc = a;
                model_en  = s[20];
            end else begin
                model_crc = div_step(model_crc, a);
            end
            exp_q.push_back({1'b0, s[19:10]});
            tag_q.push_back(s[23] ? "R1 A" : "R2 lone A");
            if (s[23]) begin
                model_crc = div_step(model_crc, b);
                exp_q.push_back({1'b0, s[9:0]});
                tag_q.push_back("R1 B");
            end
            if (s[21] && model_en) begin
                exp_q.push_back({1'b1, model_crc[9:0]});
                tag_q.push_back((s[22] && !s[23]) ? "R8 single" : crc_tag);
            end
        end
    endtask

    initial begin
        rst = 1; a_data = 0; b_data = 0; a_valid = 0; b_valid = 0;
        line_start = 0; line_end = 0; crc_en = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!out_valid && !out_is_crc && in_ready, "R9 reset", {out_valid, out_is_crc, in_ready}, 3'b001);
        rst = 0;

        // protected line of four pairs
        add(1,1,1,0,1, 10'h3A5, 10'h05A);
        add(1,1,0,0,0, 10'h1FF, 10'h200);
        add(1,1,0,0,0, 10'h000, 10'h3FF);
        add(1,1,0,1,0, 10'h123, 10'h321);
        // idle with B strobe only: ignored (R2)
        add(0,1,0,0,1, 10'h111, 10'h2AA);
        add(0,1,0,0,0, 10'h0F0, 10'h10F);
        // unprotected line, crc_en toggled mid-line (R6)
        add(1,1,1,0,0, 10'h055, 10'h0AA);
        add(1,1,0,0,1, 10'h3C3, 10'h03C);
        add(1,1,0,1,1, 10'h2B2, 10'h1D1);
        // protected line with crc_en dropped mid-line, odd length (R6, R2)
        add(1,1,1,0,1, 10'h201, 10'h102);
        add(1,1,0,0,0, 10'h2EE, 10'h177);
        add(1,0,0,1,0, 10'h3E9, 10'h000);
        // single-pixel lines (R8)
        add(1,0,1,1,1, 10'h2C7, 10'h3FF);
        add(0,0,0,0,0, 0, 0);
        add(1,0,1,1,1, 10'h001, 10'h000);
        add(1,0,1,1,0, 10'h155, 10'h000);
        // one-pair line, then back-to-back generated lines (R10)
        add(1,1,1,1,1, 10'h000, 10'h000);
        for (int ln = 0; ln < 6; ln++) begin
            for (int p = 0; p < 5; p++)
                add(1, 1, p == 0, p == 4, (ln % 3) != 2,
                    (ln * 97 + p * 131 + 7) % 1024, (ln * 53 + p * 211 + 3) % 1024);
        end

        for (int cyc = 0; cyc < 2000; cyc++) begin
            compare_cycle();
            drive_cycle();
            @(negedge clk);
            if (stim.size() == 0 && exp_q.size() == 0 && cyc > 10) break;
        end
        compare_cycle();
        check(exp_q.size() == 0, "R1 drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog R10: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule